// File: doc/BRIEF.md
# SPI Serial Clock Prescale Generator

This block produces the serial clock for an SPI master from a fast source clock. The source can first be divided by a fixed pre-divider of 16. That result is then divided by four times one more than a 4-bit modulus. The output always has an exact 50% duty cycle. The total divide ratio runs from 4 (no pre-divide, modulus 0) up to 1024 (pre-divide, modulus 15).

Along with the level output, the block gives two strobes, each one source cycle wide. They mark the cycle in which the serial clock has just gone high or just gone low, so that shift logic in the same clock domain can launch and capture data without detecting edges itself.

The divider setting is read continuously while the block is idle. While it runs, the setting is only taken up when an output period completes, so a change made during a period can never produce a short pulse.

Top module: `sclk_prescaler`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `sclk`, `sclk_rise` and `sclk_fall` are all 0. This holds even if `en` is high.
- R2: A cycle in which `en` is sampled low forces `sclk` to 0 with no strobe and clears all counters. The next enable then times its first edge from scratch.
- R3: With `prediv_sel` = 0 and `en` held high from clock edge e0 onward, `sclk` rises on edge e0+H-1 and falls on edge e0+2H-1, where H = 2*(`modulus`+1). The same pattern then repeats every 2H cycles.
- R4: With `prediv_sel` = 1, every half period is 16*H cycles long. For example, `modulus` = 3 gives a full period of 256 source cycles.
- R5: The high time and the low time of `sclk` are equal in every period.
- R6: `sclk_rise` is high for exactly one cycle, and only in the first cycle in which `sclk` reads 1.
- R7: `sclk_fall` is high for exactly one cycle, and only in the first cycle in which `sclk` reads 0 after a high phase while enabled.
- R8: A change of `modulus` or `prediv_sel` while running takes effect only after the falling edge that ends the current period. The period in progress keeps its old length.
- R9: The modulus extremes divide correctly: a value of 0 gives a period of 4 cycles and a value of 15 gives a period of 64 cycles when pre-divide is off.
- R10: The first period after an enable uses the `modulus` and `prediv_sel` values present on the edge where `en` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; when low, the output idles low |
| modulus | input | 4 | Prescale modulus; the stage divides by 4*(modulus+1) |
| prediv_sel | input | 1 | Selects the fixed divide-by-16 stage ahead of the modulus stage |
| sclk | output | 1 | Generated serial clock, 50% duty |
| sclk_rise | output | 1 | One-cycle strobe in the first high cycle of `sclk` |
| sclk_fall | output | 1 | One-cycle strobe in the first low cycle of `sclk` |

## Verification
A wrong half-period count, or a pre-divider that is out of step, shows up as a strobe in the wrong cycle at the first edge after enable. That is at most 512 cycles away. A configuration register that loads at the wrong moment stretches or shrinks the period that is in progress, so it appears at the very next falling edge after the change. Counters that are not cleared on disable show up as an early first rising edge after re-enable. Every strobe is therefore compared, cycle for cycle, against an edge schedule computed from the requested settings.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    // Width of the prescale modulus field
    localparam int PM_W = 4;
    // Default length of the fixed pre-divide stage
    localparam int PRE_DIV_DEF = 16;

    typedef struct packed {
        logic [PM_W-1:0] pm;
        logic            pre_en;
    } sclk_cfg_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_e;

    // Last count value of one half period: 2*(pm+1)-1
    function automatic logic [PM_W:0] half_last(input logic [PM_W-1:0] pm);
        return {pm, 1'b1};
    endfunction

endpackage

// File: rtl/sclk_prediv.sv
module sclk_prediv #(
    parameter int PRE_DIV = sclk_div_pkg::PRE_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pre_en,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !pre_en) begin
            cnt_q <= '0;
        end else if (cnt_q == PRE_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (!pre_en || (cnt_q == PRE_LAST));

    // R4: in pre-divide mode two ticks are never adjacent
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (en && pre_en && tick) |=> !(tick && pre_en));

endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
    import sclk_div_pkg::*;
#(
    parameter int W = sclk_div_pkg::PM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] pm,
    output logic         sclk_q,
    output edge_e        edge_q,
    output logic         period_end
);
    logic [W:0] hcnt_q;
    logic       at_last;

    assign at_last    = (hcnt_q == {pm, 1'b1});
    assign period_end = en && tick && at_last && sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt_q <= '0;
            sclk_q <= 1'b0;
            edge_q <= EDGE_NONE;
        end else if (tick && at_last) begin
            hcnt_q <= '0;
            sclk_q <= !sclk_q;
            edge_q <= sclk_q ? EDGE_FALL : EDGE_RISE;
        end else begin
            if (tick) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
            edge_q <= EDGE_NONE;
        end
    end

    // R2: a disabled cycle leaves the clock low
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sclk_q);

    // R3: the half-period counter never passes its terminal value
    assert_hcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        en |-> (hcnt_q <= half_last(pm)));

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_div_pkg::*;
#(
    parameter int PRE_DIV = sclk_div_pkg::PRE_DIV_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] modulus,
    input  logic       prediv_sel,
    output logic       sclk,
    output logic       sclk_rise,
    output logic       sclk_fall
);
    sclk_cfg_t cfg_in;
    sclk_cfg_t cfg_act;
    sclk_cfg_t cfg_eff;
    logic      running_q;
    logic      tick;
    logic      period_end;
    logic      sclk_q;
    edge_e     edge_q;

    assign cfg_in  = '{pm: modulus, pre_en: prediv_sel};
    // Idle or first enabled cycle: take the inputs directly
    assign cfg_eff = running_q ? cfg_act : cfg_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            cfg_act   <= '0;
        end else begin
            running_q <= en;
            if (!running_q || period_end) begin
                cfg_act <= cfg_in;
            end
        end
    end

    sclk_prediv #(.PRE_DIV(PRE_DIV)) u_prediv (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .pre_en (cfg_eff.pre_en),
        .tick   (tick)
    );

    sclk_phase #(.W(PM_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (tick),
        .pm         (cfg_eff.pm),
        .sclk_q     (sclk_q),
        .edge_q     (edge_q),
        .period_end (period_end)
    );

    assign sclk      = sclk_q;
    assign sclk_rise = (edge_q == EDGE_RISE);
    assign sclk_fall = (edge_q == EDGE_FALL);

    // R6: the rise strobe marks exactly the first high cycle
    assert_rise_align_R6: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |-> (sclk && !$past(sclk)));
    assert_rise_seen_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && $past(en)) |-> sclk_rise);

    // R7: the fall strobe marks exactly the first low cycle while enabled
    assert_fall_align_R7: assert property (@(posedge clk) disable iff (rst)
        sclk_fall |-> (!sclk && $past(sclk)));
    assert_fall_seen_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && $past(en)) |-> sclk_fall);

    // R8: the active setting only moves at a period boundary or when idle
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(running_q) && !$past(period_end)) |-> $stable(cfg_act));

    // R1: outputs are quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!sclk && !sclk_rise && !sclk_fall));

endmodule

// File: tb/sclk_prescaler_tb.sv
`timescale 1ns/1ps
module sclk_prescaler_tb;

    typedef struct {
        int    cyc;
        bit    rise;
        string tag;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [3:0] modulus = '0;
    logic       prediv_sel = 1'b0;
    logic       sclk, sclk_rise, sclk_fall;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sclk_prescaler u_dut (
        .clk(clk), .rst(rst), .en(en), .modulus(modulus),
        .prediv_sel(prediv_sel), .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the expected edge schedule as strobes appear
    always @(negedge clk) begin
        if (!rst && (sclk_rise || sclk_fall)) begin
            chk(!(sclk_rise && sclk_fall), "R6/R7", "both strobes", 1, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected strobe at cycle", cyc, -1);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (e.rise) begin
                    chk(sclk_rise, {e.tag, "/R6"}, "rise strobe missing at cycle", cyc, e.cyc);
                    chk(sclk == 1'b1, {e.tag, "/R6"}, "sclk level at rise", int'(sclk), 1);
                end else begin
                    chk(sclk_fall, {e.tag, "/R7"}, "fall strobe missing at cycle", cyc, e.cyc);
                    chk(sclk == 1'b0, {e.tag, "/R7"}, "sclk level at fall", int'(sclk), 0);
                end
                chk(cyc == e.cyc, {e.tag, "/R5"}, "edge cycle", cyc, e.cyc);
            end
        end
    end

    function automatic int half_len(input int pm, input bit pre);
        return 2 * (pm + 1) * (pre ? 16 : 1);
    endfunction

    task automatic push_periods(input int start, input int hp, input int n, input string tag);
        for (int j = 0; j < n; j++) begin
            exp_q.push_back('{cyc: start + hp * (2*j + 1), rise: 1'b1, tag: tag});
            exp_q.push_back('{cyc: start + hp * (2*j + 2), rise: 1'b0, tag: tag});
        end
    endtask

    task automatic stop_and_idle(input string tag);
        en = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, {tag, "/R2"}, "sclk after disable", int'(sclk), 0);
        chk(!sclk_rise && !sclk_fall, {tag, "/R2"}, "strobe after disable",
            int'(sclk_rise | sclk_fall), 0);
        chk(exp_q.size() == 0, tag, "edges still pending", exp_q.size(), 0);
        exp_q.delete();
        repeat (2) @(negedge clk);
    endtask

    // Driver: enable with a setting and schedule n full periods
    task automatic run(input int pm, input bit pre, input int n, input string tag);
        int c0, hp;
        @(negedge clk);
        modulus = 4'(pm); prediv_sel = pre; en = 1'b1;
        c0 = cyc; hp = half_len(pm, pre);
        push_periods(c0, hp, n, tag);
        repeat (2 * hp * n) @(negedge clk);
        stop_and_idle(tag);
    endtask

    // Driver: change the setting w cycles into the first period
    task automatic run_switch(input int pa, input bit ra, input int pb, input bit rb,
                              input int w, input int nb, input string tag);
        int c0, ha, hb;
        @(negedge clk);
        modulus = 4'(pa); prediv_sel = ra; en = 1'b1;
        c0 = cyc; ha = half_len(pa, ra); hb = half_len(pb, rb);
        push_periods(c0, ha, 1, tag);
        push_periods(c0 + 2*ha, hb, nb, tag);
        repeat (w) @(negedge clk);
        modulus = 4'(pb); prediv_sel = rb;
        repeat (2*ha + 2*hb*nb - w) @(negedge clk);
        stop_and_idle(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk(!sclk && !sclk_rise && !sclk_fall, "R1", "outputs in reset",
            int'({sclk, sclk_rise, sclk_fall}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk idle after reset", int'(sclk), 0);

        run(0, 1'b0, 3, "R9");        // ratio 4
        run(15, 1'b0, 2, "R9");       // ratio 64
        run(5, 1'b0, 2, "R3");
        run(3, 1'b1, 2, "R4");        // ratio 256
        run(0, 1'b1, 2, "R4");
        run(9, 1'b0, 1, "R10");

        // R2: abort after one rise, then a fresh enable restarts timing
        begin
            int c0;
            @(negedge clk);
            modulus = 4'd2; prediv_sel = 1'b0; en = 1'b1; c0 = cyc;
            exp_q.push_back('{cyc: c0 + 6, rise: 1'b1, tag: "R2"});
            repeat (9) @(negedge clk);
            stop_and_idle("R2");
            @(negedge clk);
            modulus = 4'd2; en = 1'b1; c0 = cyc;
            repeat (4) @(negedge clk);
            stop_and_idle("R2");
        end
        run(2, 1'b0, 2, "R2");

        run_switch(1, 1'b0, 4, 1'b0, 1, 2, "R8");
        run_switch(2, 1'b1, 0, 1'b0, 40, 3, "R8");
        run_switch(6, 1'b0, 1, 1'b1, 20, 1, "R8");

        // R1: reset while running
        @(negedge clk);
        modulus = 4'd1; prediv_sel = 1'b0; en = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!sclk && !sclk_rise && !sclk_fall, "R1", "outputs after mid-run reset",
            int'({sclk, sclk_rise, sclk_fall}), 0);
        @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk held in reset", int'(sclk), 0);
        en = 1'b0; rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0 && sclk == 1'b0, "R1", "no activity after reset",
            int'(sclk), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule